// File: doc/BRIEF.md
# Multi-Lane Serial Audio Transmitter

This block is the output stage of a stereo audio path. It runs entirely on an oversampling clock from an external frequency synthesizer, forwards that clock to the converters, and derives a bit clock and a word-select clock from it through two chained programmable dividers. Four data lanes each carry their own stereo pair. Each lane uses the common format where the word-select level marks the channel and each word starts one bit clock after the word-select edge. Words are sent most significant bit first, and the data changes on the bit-clock falling edge.

Upstream logic hands over one group of four stereo pairs at a time through a valid/ready handshake. The group waits in a one-entry holding buffer and is adopted only at the start of a frame. If nothing is waiting at that point, the pair already on the lanes is sent again, and a flag records that this happened. Divider ratios and the sample width are plain inputs. They are sampled only at frame starts, so a change made in the middle of a frame cannot produce a truncated clock phase.

Top module: `ser_audio_tx`

## Requirements
- R1: `osclk_o` carries the `osclk_i` input unchanged.
- R2: One `sck_o` period lasts P = max(`sck_div_i`,1)+1 oversampling cycles. The low phase is floor(P/2) cycles long and the high phase covers the rest.
- R3: A frame lasts F = max(`ws_div_i`,1)+1 bit-clock periods. `ws_o` is low for the first F/2 of them (rounded down) and high for the rest.
- R4: `ws_o` and every `sd_o` bit change only at a falling edge of `sck_o`.
- R5: Each slot is sent most significant bit first. Its first bit follows the `ws_o` edge by one bit-clock period, and its last position coincides with the next `ws_o` edge. Left words go out while `ws_o` is low and right words while it is high.
- R6: When `wide_i` is 1 the words are 32 bits wide. When it is 0 they are 16 bits, taken from bits [15:0] of each field. Slot positions past the word width are sent as 0.
- R7: Lane k sends its left word from `in_data_i[64k+31:64k]` and its right word from `in_data_i[64k+63:64k+32]`.
- R8: `in_ready_o` is 1 while the holding buffer is empty. It is 0 in the cycle after an accepted transfer. It returns to 1 only after the buffer content has been adopted at a frame start.
- R9: The buffer content is adopted on the bit-clock falling edge that starts a left word. If the buffer is empty at that edge, the previous pair is repeated and `underrun_o` goes to 1. It then stays at 1 until reset. While the buffer is refilled in time, `underrun_o` stays at 0.
- R10: Divider and width inputs are sampled during reset and at the bit-clock falling edge where `ws_o` falls. A change made in mid-frame leaves the running frame's timing untouched.
- R11: Reset (synchronous, active high) forces `sck_o`, `ws_o`, `sd_o` and `underrun_o` low and `in_ready_o` high. The pair on the lanes is all zeros until the first group is adopted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osclk_i | input | 1 | Oversampling clock from the synthesizer |
| rst_i | input | 1 | Synchronous active-high reset |
| sck_div_i | input | 8 | Bit-clock divider setting, ratio value+1 |
| ws_div_i | input | 8 | Frame divider setting, frame = value+1 bit clocks |
| wide_i | input | 1 | 1: 32-bit words, 0: 16-bit words |
| in_valid_i | input | 1 | Group of sample pairs offered |
| in_ready_o | output | 1 | Holding buffer empty |
| in_data_i | input | 256 | Four stereo pairs, 32-bit fields |
| osclk_o | output | 1 | Forwarded oversampling clock |
| sck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word-select clock, low for left |
| sd_o | output | 4 | Serial data, one bit per lane |
| underrun_o | output | 1 | Sticky repeat flag |

## Verification
Every serial bit leaves on a bit-clock falling edge and is due at the next rising edge. The bench observes the ports on the oversampling falling edge, rebuilds each slot on the `sck_o` rises, and closes the slot at each `ws_o` edge. An accepted group must appear in the first frame whose `ws_o` fall comes after its acceptance. It keeps repeating in later frames until another group arrives, and the flag must already be set one bit clock after an unfed `ws_o` fall. Divider changes are judged by rise-to-rise and fall-to-fall distances: first inside the frame in which the change was made, then in the frame that follows the next `ws_o` fall.

// File: rtl/ser_audio_pkg.sv
package ser_audio_pkg;

  localparam int SLOT_W   = 32;
  localparam int NARROW_W = 16;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  // right word in the upper half, matching the input bus layout
  typedef struct packed {
    logic [SLOT_W-1:0] right;
    logic [SLOT_W-1:0] left;
  } pair_t;

endpackage

// File: rtl/sat_sck_gen.sv
module sat_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sck_o,
  output logic             fall_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_nxt;
  logic [DIV_W-1:0] div_eff;
  logic [DIV_W-1:0] half;

  always_comb begin
    div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
    half    = DIV_W'(({1'b0, div_eff} + (DIV_W+1)'(1)) >> 1);
    fall_o  = (cnt_q >= div_eff);
    cnt_nxt = fall_o ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      sck_o <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      sck_o <= (cnt_nxt >= half);
    end
  end

endmodule

// File: rtl/sat_bit_ctr.sv
module sat_bit_ctr
  import ser_audio_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             ws_o,
  output logic             frame_o,
  output logic             load_o,
  output chan_e            chan_o,
  output logic [CNT_W-1:0] pos_o
);

  logic [CNT_W-1:0] b_q;
  logic [CNT_W-1:0] b_nxt;
  logic [CNT_W-1:0] last_eff;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] d;

  always_comb begin
    last_eff = (last_i == '0) ? CNT_W'(1) : last_i;
    half     = CNT_W'(({1'b0, last_eff} + (CNT_W+1)'(1)) >> 1);
    frame_o  = adv_i && (b_q >= last_eff);
    load_o   = adv_i && (b_q == '0);
    if (frame_o)    b_nxt = '0;
    else if (adv_i) b_nxt = b_q + CNT_W'(1);
    else            b_nxt = b_q;
    // the bit leaving at this edge belongs to slot position d (one-bit lag)
    d = (b_nxt == '0) ? last_eff : b_nxt - CNT_W'(1);
    if (d < half) begin
      chan_o = CH_LEFT;
      pos_o  = d;
    end else begin
      chan_o = CH_RIGHT;
      pos_o  = d - half;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      b_q  <= '0;
      ws_o <= 1'b0;
    end else begin
      b_q  <= b_nxt;
      ws_o <= (b_nxt >= half);
    end
  end

endmodule

// File: rtl/sat_lane_ser.sv
module sat_lane_ser
  import ser_audio_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             shift_i,
  input  pair_t            pair_i,
  input  chan_e            chan_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             wide_i,
  output logic             sd_o
);

  localparam int IDX_W = $clog2(SLOT_W);

  logic [SLOT_W-1:0] word;
  logic [31:0]       w_bits;
  logic [31:0]       pos_ext;
  logic              bit_nxt;

  always_comb begin
    word    = (chan_i == CH_RIGHT) ? pair_i.right : pair_i.left;
    w_bits  = wide_i ? 32'(SLOT_W) : 32'(NARROW_W);
    pos_ext = 32'(pos_i);
    if (pos_ext < w_bits) bit_nxt = word[IDX_W'(w_bits - 32'd1 - pos_ext)];
    else                  bit_nxt = 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        sd_o <= 1'b0;
    else if (shift_i) sd_o <= bit_nxt;
  end

endmodule

// File: rtl/ser_audio_tx.sv
module ser_audio_tx
  import ser_audio_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DIV_W = 8,
  parameter int FRM_W = 8
) (
  input  logic                          osclk_i,
  input  logic                          rst_i,
  input  logic [DIV_W-1:0]              sck_div_i,
  input  logic [FRM_W-1:0]              ws_div_i,
  input  logic                          wide_i,
  input  logic                          in_valid_i,
  output logic                          in_ready_o,
  input  logic [LANES*2*SLOT_W-1:0]     in_data_i,
  output logic                          osclk_o,
  output logic                          sck_o,
  output logic                          ws_o,
  output logic [LANES-1:0]              sd_o,
  output logic                          underrun_o
);

  localparam int PAIR_BITS = 2 * SLOT_W;

  logic [DIV_W-1:0] sck_div_q;
  logic [FRM_W-1:0] ws_div_q;
  logic             wide_q;

  logic             fall;
  logic             frame_start;
  logic             load_stb;
  chan_e            chan;
  logic [FRM_W-1:0] pos;

  logic             hold_full_q;
  logic             underrun_q;
  logic             accept;
  logic             adopt;

  pair_t hold_q [LANES];
  pair_t cur_q  [LANES];
  pair_t src    [LANES];

  assign osclk_o    = osclk_i;
  assign in_ready_o = ~hold_full_q;
  assign underrun_o = underrun_q;
  assign accept     = in_valid_i && !hold_full_q;
  assign adopt      = load_stb && hold_full_q;

  // settings follow the inputs only at reset and at frame starts
  always_ff @(posedge osclk_i) begin
    if (rst_i || frame_start) begin
      sck_div_q <= sck_div_i;
      ws_div_q  <= ws_div_i;
      wide_q    <= wide_i;
    end
  end

  sat_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk_i  (osclk_i),
    .rst_i  (rst_i),
    .div_i  (sck_div_q),
    .sck_o  (sck_o),
    .fall_o (fall)
  );

  sat_bit_ctr #(.CNT_W(FRM_W)) u_ctr (
    .clk_i   (osclk_i),
    .rst_i   (rst_i),
    .adv_i   (fall),
    .last_i  (ws_div_q),
    .ws_o    (ws_o),
    .frame_o (frame_start),
    .load_o  (load_stb),
    .chan_o  (chan),
    .pos_o   (pos)
  );

  always_ff @(posedge osclk_i) begin
    if (rst_i) begin
      hold_full_q <= 1'b0;
      underrun_q  <= 1'b0;
    end else begin
      if (load_stb) begin
        if (hold_full_q) hold_full_q <= 1'b0;
        else             underrun_q  <= 1'b1;
      end
      if (accept) hold_full_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge osclk_i) begin
      if (accept) hold_q[g] <= pair_t'(in_data_i[g*PAIR_BITS +: PAIR_BITS]);
    end

    always_ff @(posedge osclk_i) begin
      if (rst_i)      cur_q[g] <= '0;
      else if (adopt) cur_q[g] <= hold_q[g];
    end

    assign src[g] = adopt ? hold_q[g] : cur_q[g];

    sat_lane_ser #(.POS_W(FRM_W)) u_ser (
      .clk_i   (osclk_i),
      .rst_i   (rst_i),
      .shift_i (fall),
      .pair_i  (src[g]),
      .chan_i  (chan),
      .pos_i   (pos),
      .wide_i  (wide_q),
      .sd_o    (sd_o[g])
    );
  end

endmodule

// File: rtl/ser_audio_tx_chk.sv
module ser_audio_tx_chk #(
  parameter int LANES = 4
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             sck_i,
  input logic             ws_i,
  input logic [LANES-1:0] sd_i,
  input logic             valid_i,
  input logic             ready_i,
  input logic             underrun_i,
  input logic             load_i
);

  assert_ws_on_fall_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (ws_i != $past(ws_i)) |-> $fell(sck_i));

  assert_sd_on_fall_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (sd_i != $past(sd_i)) |-> $fell(sck_i));

  assert_ready_drop_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_i && ready_i) |=> !ready_i);

  assert_ready_rise_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ready_i) |-> $past(load_i));

  assert_underrun_sticky_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    underrun_i |=> underrun_i);

endmodule

bind ser_audio_tx ser_audio_tx_chk #(.LANES(LANES)) u_chk (
  .clk_i      (osclk_i),
  .rst_i      (rst_i),
  .sck_i      (sck_o),
  .ws_i       (ws_o),
  .sd_i       (sd_o),
  .valid_i    (in_valid_i),
  .ready_i    (in_ready_o),
  .underrun_i (underrun_o),
  .load_i     (load_stb)
);

// File: tb/sim_ser_audio_tx.sv
`timescale 1ns/1ps
module sim_ser_audio_tx;

  localparam int LN  = 4;
  localparam int BUS = LN * 64;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [7:0]     sck_div = 8'd3;
  logic [7:0]     ws_div = 8'd63;
  logic           wide = 1'b1;
  logic           valid = 1'b0;
  logic [BUS-1:0] data = '0;
  logic           ready, osclk_out, sck, ws, underrun;
  logic [LN-1:0]  sd;

  always #10 clk = ~clk;

  ser_audio_tx u0 (
    .osclk_i    (clk),
    .rst_i      (rst),
    .sck_div_i  (sck_div),
    .ws_div_i   (ws_div),
    .wide_i     (wide),
    .in_valid_i (valid),
    .in_ready_o (ready),
    .in_data_i  (data),
    .osclk_o    (osclk_out),
    .sck_o      (sck),
    .ws_o       (ws),
    .sd_o       (sd),
    .underrun_o (underrun)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // ---------------- port monitor / slot decoder ----------------
  int cyc, last_rise, last_period, nrise, phase_len, last_low, last_high, min_phase;
  int last_wsfall, last_wsper, last_wslow, nwsfall, nfr, viol;
  bit first_tr, started, left_ok, cur_ws, p_sck, p_ws;
  logic [LN-1:0] p_sd;
  logic [63:0] acc [LN];
  logic [63:0] lacc [LN];
  logic [63:0] fr_l [LN][32];
  logic [63:0] fr_r [LN][32];

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; last_rise = 0; last_period = 0; nrise = 0; phase_len = 0;
      last_low = 0; last_high = 0; min_phase = 99; first_tr = 1'b1;
      last_wsfall = 0; last_wsper = 0; last_wslow = 0; nwsfall = 0; nfr = 0;
      started = 1'b0; left_ok = 1'b0; cur_ws = 1'b0;
      p_sck = sck; p_ws = ws; p_sd = sd;
      for (int l = 0; l < LN; l++) begin acc[l] = '0; lacc[l] = '0; end
    end else begin
      cyc++;
      if (sck != p_sck) begin
        if (p_sck) last_high = phase_len; else last_low = phase_len;
        if (!first_tr && phase_len < min_phase) min_phase = phase_len;
        first_tr = 1'b0;
        phase_len = 1;
      end else phase_len++;
      if (!(p_sck && !sck) && ((ws != p_ws) || (sd != p_sd))) viol++;
      if (sck && !p_sck) begin
        last_period = cyc - last_rise; last_rise = cyc; nrise++;
        for (int l = 0; l < LN; l++) acc[l] = {acc[l][62:0], sd[l]};
        if (ws != cur_ws) begin
          if (!cur_ws) begin
            for (int l = 0; l < LN; l++) lacc[l] = acc[l];
            left_ok = started;
          end else begin
            if (left_ok && nfr < 32) begin
              for (int l = 0; l < LN; l++) begin
                fr_l[l][nfr] = lacc[l];
                fr_r[l][nfr] = acc[l];
              end
              nfr++;
            end
            started = 1'b1;
          end
          for (int l = 0; l < LN; l++) acc[l] = '0;
          cur_ws = ws;
        end
      end
      if (ws != p_ws) begin
        if (!ws) begin
          last_wsper = cyc - last_wsfall; last_wsfall = cyc; nwsfall++;
        end else last_wslow = cyc - last_wsfall;
      end
      p_sck = sck; p_ws = ws; p_sd = sd;
    end
  end

  // ---------------- helpers ----------------
  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_smp(input int seed, input int l, input int c);
    return (32'(seed) * 32'h9E37_79B1) ^ (32'(l) * 32'h0123_4567) ^ (32'(c) * 32'h80F0_0F01) ^ 32'h5000_000A;
  endfunction

  function automatic logic [BUS-1:0] mk_bus(input int seed);
    logic [BUS-1:0] b;
    for (int l = 0; l < LN; l++)
      for (int c = 0; c < 2; c++) b[(2*l+c)*32 +: 32] = mk_smp(seed, l, c);
    return b;
  endfunction

  function automatic logic [63:0] exp_slot(input logic [31:0] s, input bit wd, input int h);
    logic [63:0] v;
    v = wd ? {32'h0, s} : {48'h0, s[15:0]};
    return v << (h - (wd ? 32 : 16));
  endfunction

  function automatic logic [63:0] hmask(input int h);
    return (h >= 64) ? '1 : ((64'd1 << h) - 64'd1);
  endfunction

  task automatic reset_dut(input logic [7:0] sdv, input logic [7:0] wdv, input bit wd);
    rst = 1'b1; valid = 1'b0; sck_div = sdv; ws_div = wdv; wide = wd;
    repeat (3) step();
    rst = 1'b0;
  endtask

  task automatic send(input int seed);
    data = mk_bus(seed); valid = 1'b1;
    while (!ready) step();
    step();
    valid = 1'b0;
    chk(ready == 1'b0, "R8 ready low after accept", ready, 0);
  endtask

  task automatic wait_frames(input int n);
    while (nfr < n) step();
  endtask

  task automatic check_frame(input int idx, input int seed, input bit wd, input int h, input string req);
    for (int l = 0; l < LN; l++) begin
      logic [63:0] el, er;
      el = exp_slot(mk_smp(seed, l, 0), wd, h);
      er = exp_slot(mk_smp(seed, l, 1), wd, h);
      chk((fr_l[l][idx] & hmask(h)) == el, {req, " left"}, fr_l[l][idx] & hmask(h), el);
      chk((fr_r[l][idx] & hmask(h)) == er, {req, " right"}, fr_r[l][idx] & hmask(h), er);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    reset_dut(8'd3, 8'd63, 1'b1);
    rst = 1'b1;
    step();
    chk(sck == 1'b0, "R11 sck", sck, 0);
    chk(ws == 1'b0, "R11 ws", ws, 0);
    chk(sd == '0, "R11 sd", sd, 0);
    chk(underrun == 1'b0, "R11 underrun", underrun, 0);
    chk(ready == 1'b1, "R11 ready", ready, 1);
    chk(osclk_out == clk, "R1 low phase", osclk_out, clk);
    #10;
    chk(osclk_out == clk, "R1 high phase", osclk_out, clk);
    step();
    rst = 1'b0;
  endtask

  task automatic t_clocking();
    reset_dut(8'd3, 8'd63, 1'b1);
    while (nwsfall < 3) step();
    chk(last_period == 4, "R2 period", 64'(last_period), 4);
    chk(last_low == 2, "R2 low phase", 64'(last_low), 2);
    chk(last_high == 2, "R2 high phase", 64'(last_high), 2);
    chk(last_wsper == 256, "R3 frame length", 64'(last_wsper), 256);
    chk(last_wslow == 128, "R3 left half", 64'(last_wslow), 128);
    wait_frames(1);
    for (int l = 0; l < LN; l++)
      chk(fr_l[l][0] == 0 && fr_r[l][0] == 0, "R11 zero pair", fr_l[l][0] | fr_r[l][0], 0);
    chk(underrun == 1'b1, "R9 empty at first frame", underrun, 1);
    reset_dut(8'd4, 8'd63, 1'b1);
    while (nrise < 4) step();
    chk(last_period == 5, "R2 odd period", 64'(last_period), 5);
    chk(last_low == 2, "R2 odd low", 64'(last_low), 2);
    chk(last_high == 3, "R2 odd high", 64'(last_high), 3);
  endtask

  task automatic t_stream();
    reset_dut(8'd3, 8'd63, 1'b1);
    send(1); send(2); send(3); send(4);
    wait_frames(3);
    chk(underrun == 1'b0, "R9 no flag while fed", underrun, 0);
    check_frame(0, 2, 1'b1, 32, "R5 R7 frame0");
    check_frame(1, 3, 1'b1, 32, "R5 R7 frame1");
    check_frame(2, 4, 1'b1, 32, "R5 R7 frame2");
    wait_frames(5);
    check_frame(3, 4, 1'b1, 32, "R9 repeat1");
    check_frame(4, 4, 1'b1, 32, "R9 repeat2");
    chk(underrun == 1'b1, "R9 flag on repeat", underrun, 1);
    chk(ready == 1'b1, "R8 ready when empty", ready, 1);
  endtask

  task automatic t_narrow();
    reset_dut(8'd3, 8'd63, 1'b0);
    send(7); send(8);
    wait_frames(1);
    check_frame(0, 8, 1'b0, 32, "R6 16b in 32 slot");
    reset_dut(8'd3, 8'd31, 1'b0);
    send(9); send(10);
    wait_frames(1);
    check_frame(0, 10, 1'b0, 16, "R6 16b in 16 slot");
  endtask

  task automatic t_retime();
    int base, r0;
    reset_dut(8'd3, 8'd63, 1'b1);
    while (nwsfall < 1) step();
    while (ws == 1'b0) step();
    sck_div = 8'd5; ws_div = 8'd31;
    r0 = nrise;
    while (nrise < r0 + 2) step();
    chk(last_period == 4, "R10 mid-frame period kept", 64'(last_period), 4);
    base = nwsfall;
    while (nwsfall < base + 2) step();
    chk(last_period == 6, "R10 new period", 64'(last_period), 6);
    chk(last_wsper == 192, "R10 new frame length", 64'(last_wsper), 192);
    chk(min_phase >= 2, "R10 no short phase", 64'(min_phase), 2);
  endtask

  initial begin
    t_reset();
    t_clocking();
    t_stream();
    t_narrow();
    t_retime();
    chk(viol == 0, "R4 changes only at sck fall", 64'(viol), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule